// File: doc/BRIEF.md
# Segment Selector Access Query Unit

This unit answers privilege and type queries about a segment selector without loading it into a segment register. Each request carries a 16-bit selector, one of four query kinds, the current privilege level, the processor mode and the operand size. From the selector the unit locates the 8-byte descriptor in the global or the local descriptor table. It checks the descriptor against the table limit, fetches it as two 32-bit words over a simple read port, and applies the acceptance rules of the chosen query.

The four queries are: fetch access rights, fetch segment limit, verify readable and verify writable. Each one ends with a single-cycle `done` pulse. The pulse carries a zero-flag result and, for the two fetch queries when they succeed, a destination value with a write enable. The query kinds are only defined in protected mode. In any other mode the unit reports an undefined-opcode condition and reads nothing. Instruction decode, register writeback and address translation belong to the surrounding pipeline.

Top module: `seg_query_unit`

## Requirements
- R1: When `req_mode` is not 1 (protected), a request ends one cycle later with `done`=1, `undef_op`=1, `zf`=0 and `result_we`=0, and no memory read is made.
- R2: A selector whose bits 15:2 are all zero ends one cycle later with `zf`=0 and `result_we`=0, and no memory read is made.
- R3: Selector bit 2 picks the table (0 global, 1 local). The descriptor address is the table base plus the index (bits 15:3) times 8. It is read as two words, the low word at that address and then the high word at address+4.
- R4: If the descriptor's last byte (index*8+7) lies beyond the selected table limit, the result is `zf`=0 and nothing is written, with no memory read.
- R5: The privilege check fails when the DPL (high word bits 14:13) is below the CPL or below the selector RPL (bits 1:0). Conforming code (S=1, type bits 3:2 = 11) skips this check for the access-rights and limit queries.
- R6: Access-rights query (op 0): on success the value is the high word ANDed with 0x00FFFF00 at 32-bit size, or with 0x0000FF00 at 16-bit size.
- R7: For system descriptors (S, high bit 12, = 0), the access-rights query accepts only types 1, 2, 3, 4, 5, 9, 11 and 12. Any other type gives `zf`=0.
- R8: Limit query (op 1): the limit is low-word bits 15:0 joined with high-word bits 19:16. When the granularity bit (high bit 23) is set, it is shifted left 12 with 0xFFF ORed in.
- R9: The limit query accepts only system types 1, 2, 3, 9 and 11. At 16-bit operand size only limit bits 15:0 are returned, with the upper half zero.
- R10: Verify-readable (op 2) fails for system descriptors and for code without the readable bit (type bit 1). It passes readable conforming code at any privilege. All other code and data segments must pass the privilege check.
- R11: Verify-writable (op 3) fails for system descriptors, for code (type bit 3) and for data without the writable bit (type bit 1). Writable data must pass the privilege check.
- R12: `done` is a one-cycle pulse per request. `result_we` is raised only together with `done` and `zf`=1, and never for the two verify queries. After reset `done`, `zf` and `result_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 access rights, 1 limit, 2 verify read, 3 verify write |
| req_sel | input | 16 | Selector under query |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 reserved |
| req_op32 | input | 1 | 1 for 32-bit operand size |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_base | input | ADDR_W | Local table base address |
| ldt_limit | input | 16 | Local table byte limit |
| mem_rd_en | output | 1 | Read request, one cycle |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 32 | Read data |
| mem_rd_valid | input | 1 | Read data valid |
| done | output | 1 | Result pulse |
| zf | output | 1 | Zero-flag result |
| result_we | output | 1 | Destination value is to be written |
| result | output | 32 | Destination value |
| undef_op | output | 1 | Undefined-opcode condition, with `done` |

## Verification
The bench builds the unit with the default 32-bit address width. It places a 16-entry global table at address 0 and an 8-entry local table at 0x200, and answers reads after one cycle of latency. The table limits are small, so random indices up to 19 reach past either table and exercise the limit rejection, while the in-range slots hold random words that cover every type, DPL and granularity combination. Directed descriptors add the conforming, execute-only, read-only and gate corners together with a page-granular limit.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

    typedef enum logic [1:0] {
        OP_ACC = 2'd0,
        OP_LIM = 2'd1,
        OP_VRD = 2'd2,
        OP_VWR = 2'd3
    } sq_op_e;

    localparam logic [1:0] MODE_PROT = 2'd1;

    typedef struct packed {
        logic        zf;
        logic        we;
        logic [31:0] value;
    } verdict_t;

    // system types accepted by the access-rights query
    function automatic logic acc_sys_ok(input logic [3:0] t);
        case (t)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12: acc_sys_ok = 1'b1;
            default: acc_sys_ok = 1'b0;
        endcase
    endfunction

    // system types accepted by the limit query
    function automatic logic lim_sys_ok(input logic [3:0] t);
        case (t)
            4'd1, 4'd2, 4'd3, 4'd9, 4'd11: lim_sys_ok = 1'b1;
            default: lim_sys_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] byte_limit(input logic [19:0] raw, input logic gran);
        byte_limit = gran ? {raw, 12'hFFF} : {12'h000, raw};
    endfunction

    function automatic logic visible(input logic [1:0] dpl, input logic [1:0] cpl,
                                     input logic [1:0] rpl);
        visible = (dpl >= cpl) && (dpl >= rpl);
    endfunction

endpackage

// File: rtl/sqp_locate.sv
module sqp_locate #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 13,
    parameter int LIM_W  = 16
) (
    input  logic [IDX_W:0]    sel_upper,   // {index, table bit}
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [LIM_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [LIM_W-1:0]  ldt_limit,
    output logic              is_null,
    output logic              beyond,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int OFF_W = IDX_W + 4;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [OFF_W-1:0]  last_byte;
    logic [OFF_W-1:0]  lim_ext;
    logic [ADDR_W-1:0] base;

    always_comb begin
        idx       = sel_upper[IDX_W:1];
        use_local = sel_upper[0];
        is_null   = (sel_upper == '0);
        last_byte = {1'b0, idx, 3'b111};
        lim_ext   = OFF_W'(use_local ? ldt_limit : gdt_limit);
        beyond    = last_byte > lim_ext;
        base      = use_local ? ldt_base : gdt_base;
        desc_addr = base + ADDR_W'({idx, 3'b000});
    end
endmodule

// File: rtl/sqp_judge.sv
module sqp_judge
    import sqp_pkg::*;
(
    input  sq_op_e      op,
    input  logic        op32,
    input  logic [1:0]  cpl,
    input  logic [1:0]  rpl,
    input  logic [15:0] lo_half,
    input  logic [31:0] hi,
    output verdict_t    verdict
);
    logic [3:0]  typ;
    logic        seg, is_code, conf, rw, pok, ok;
    logic [31:0] lim;

    always_comb begin
        typ     = hi[11:8];
        seg     = hi[12];
        is_code = typ[3];
        conf    = typ[2];
        rw      = typ[1];
        pok     = visible(hi[14:13], cpl, rpl);
        lim     = byte_limit({hi[19:16], lo_half}, hi[23]);
        ok      = 1'b0;
        verdict = '0;
        case (op)
            OP_ACC: begin
                ok = seg ? ((is_code && conf) || pok) : (acc_sys_ok(typ) && pok);
                verdict.value = op32 ? (hi & 32'h00FF_FF00) : {16'h0, hi[15:8], 8'h00};
            end
            OP_LIM: begin
                ok = seg ? ((is_code && conf) || pok) : (lim_sys_ok(typ) && pok);
                verdict.value = op32 ? lim : {16'h0, lim[15:0]};
            end
            OP_VRD: begin
                if (!seg)                 ok = 1'b0;
                else if (!is_code)        ok = pok;
                else if (!rw)             ok = 1'b0;
                else if (conf)            ok = 1'b1;
                else                      ok = pok;
            end
            default: begin
                ok = seg && !is_code && rw && pok;
            end
        endcase
        verdict.zf = ok;
        verdict.we = ok && (op == OP_ACC || op == OP_LIM);
        if (!verdict.we) verdict.value = '0;
    end
endmodule

// File: rtl/seg_query_unit.sv
module seg_query_unit
    import sqp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_mode,
    input  logic              req_op32,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [15:0]       ldt_limit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              done,
    output logic              zf,
    output logic              result_we,
    output logic [31:0]       result,
    output logic              undef_op
);
    localparam int SEL_W = 16;
    localparam int IDX_W = SEL_W - 3;

    typedef enum logic [2:0] {
        S_IDLE, S_ASK_LO, S_GET_LO, S_ASK_HI, S_GET_HI, S_JUDGE
    } st_e;

    st_e               state;
    sq_op_e            op_q;
    logic              op32_q;
    logic [1:0]        cpl_q, rpl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q, hi_q;

    logic              is_null, beyond;
    logic [ADDR_W-1:0] desc_addr;
    verdict_t          verdict;

    sqp_locate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LIM_W(16)) u_locate (
        .sel_upper (req_sel[SEL_W-1:2]),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .is_null   (is_null),
        .beyond    (beyond),
        .desc_addr (desc_addr)
    );

    sqp_judge u_judge (
        .op      (op_q),
        .op32    (op32_q),
        .cpl     (cpl_q),
        .rpl     (rpl_q),
        .lo_half (lo_q[15:0]),
        .hi      (hi_q),
        .verdict (verdict)
    );

    always_comb begin
        mem_rd_en   = (state == S_ASK_LO) || (state == S_ASK_HI);
        mem_rd_addr = (state == S_ASK_HI) ? addr_q + ADDR_W'(4) : addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_q      <= OP_ACC;
            op32_q    <= 1'b0;
            cpl_q     <= '0;
            rpl_q     <= '0;
            addr_q    <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            done      <= 1'b0;
            zf        <= 1'b0;
            result_we <= 1'b0;
            result    <= '0;
            undef_op  <= 1'b0;
        end else begin
            done      <= 1'b0;
            result_we <= 1'b0;
            undef_op  <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= sq_op_e'(req_op);
                    op32_q <= req_op32;
                    cpl_q  <= req_cpl;
                    rpl_q  <= req_sel[1:0];
                    addr_q <= desc_addr;
                    if (req_mode != MODE_PROT) begin
                        done     <= 1'b1;
                        undef_op <= 1'b1;
                        zf       <= 1'b0;
                        result   <= '0;
                    end else if (is_null || beyond) begin
                        done   <= 1'b1;
                        zf     <= 1'b0;
                        result <= '0;
                    end else begin
                        state <= S_ASK_LO;
                    end
                end
                S_ASK_LO: state <= S_GET_LO;
                S_GET_LO: if (mem_rd_valid) begin
                    lo_q  <= mem_rd_data;
                    state <= S_ASK_HI;
                end
                S_ASK_HI: state <= S_GET_HI;
                S_GET_HI: if (mem_rd_valid) begin
                    hi_q  <= mem_rd_data;
                    state <= S_JUDGE;
                end
                default: begin
                    done      <= 1'b1;
                    zf        <= verdict.zf;
                    result_we <= verdict.we;
                    result    <= verdict.value;
                    state     <= S_IDLE;
                end
            endcase
        end
    end

    p_undef_mode_r1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req_valid && req_mode != MODE_PROT)
        |=> (done && undef_op && !zf && !result_we));

    p_null_fast_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req_valid && req_mode == MODE_PROT && req_sel[15:2] == '0)
        |=> (done && !zf && !result_we && !mem_rd_en));

    p_short_limit_r9: assert property (@(posedge clk) disable iff (rst)
        (done && result_we && !op32_q) |-> (result[31:16] == 16'h0));

    p_verify_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_VRD || op_q == OP_VWR)) |-> !result_we);

    p_we_with_zf_r12: assert property (@(posedge clk) disable iff (rst)
        result_we |-> (zf && done));

    p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_ASK_HI) |-> (mem_rd_addr - addr_q == ADDR_W'(4)));

endmodule

// File: tb/seg_query_unit_tb.sv
`timescale 1ns/1ps
module seg_query_unit_tb_top;
    localparam int ADDR_W = 32;
    localparam logic [31:0] GBASE = 32'h0000_0000;
    localparam logic [15:0] GLIM  = 16'h007F;
    localparam logic [31:0] LBASE = 32'h0000_0200;
    localparam logic [15:0] LLIM  = 16'h003F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [15:0]       req_sel = '0;
    logic [1:0]        req_cpl = '0;
    logic [1:0]        req_mode = 2'd1;
    logic              req_op32 = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [31:0]       mem_rd_data;
    logic              mem_rd_valid;
    logic              done, zf, result_we, undef_op;
    logic [31:0]       result;

    logic [31:0] mem [0:255];
    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    logic [31:0] rd_addr [0:1];

    seg_query_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_cpl(req_cpl), .req_mode(req_mode), .req_op32(req_op32),
        .gdt_base(GBASE), .gdt_limit(GLIM), .ldt_base(LBASE), .ldt_limit(LLIM),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_rd_valid(mem_rd_valid), .done(done), .zf(zf), .result_we(result_we),
        .result(result), .undef_op(undef_op)
    );

    always_ff @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        mem_rd_data  <= mem[mem_rd_addr[9:2]];
    end

    always @(negedge clk) begin
        if (mem_rd_en) begin
            if (reads < 2) rd_addr[reads] = mem_rd_addr;
            reads = reads + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent expectation
    function automatic void expect_of(input logic [1:0] op, input logic [15:0] sel,
            input logic [1:0] cpl, input logic [1:0] mode, input logic op32,
            output logic e_undef, output logic e_zf, output logic e_we,
            output logic [31:0] e_val, output int e_reads, output logic [31:0] e_addr);
        logic [31:0] lo, hi, lim, base;
        logic [3:0]  t;
        logic [15:0] tl;
        int idx;
        logic priv, pass;
        e_undef = (mode != 2'd1); e_zf = 0; e_we = 0; e_val = 0; e_reads = 0; e_addr = 0;
        if (e_undef || sel[15:2] == 0) return;
        idx  = int'(sel[15:3]);
        base = sel[2] ? LBASE : GBASE;
        tl   = sel[2] ? LLIM : GLIM;
        if (idx * 8 + 7 > int'(tl)) return;
        e_reads = 2;
        e_addr  = base + 32'(idx * 8);
        lo = mem[e_addr[9:2]];
        hi = mem[e_addr[9:2] + 8'd1];
        t  = hi[11:8];
        priv = !((hi[14:13] < cpl) || (hi[14:13] < sel[1:0]));
        lim  = {12'h0, hi[19:16], lo[15:0]};
        if (hi[23]) lim = (lim << 12) | 32'hFFF;
        pass = 0;
        if (op == 2'd0) begin
            if (hi[12]) pass = (t[3:2] == 2'b11) ? 1'b1 : priv;
            else pass = priv && (t inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12});
            e_val = op32 ? {8'h0, hi[23:8], 8'h0} : {16'h0, hi[15:8], 8'h0};
        end else if (op == 2'd1) begin
            if (hi[12]) pass = (t[3:2] == 2'b11) ? 1'b1 : priv;
            else pass = priv && (t inside {4'd1, 4'd2, 4'd3, 4'd9, 4'd11});
            e_val = op32 ? lim : {16'h0, lim[15:0]};
        end else if (op == 2'd2) begin
            if (!hi[12]) pass = 0;
            else if (t[3] && t[2] && t[1]) pass = 1;
            else if (t[3] && !t[1]) pass = 0;
            else pass = priv;
        end else begin
            pass = hi[12] && !t[3] && t[1] && priv;
        end
        e_zf = pass;
        e_we = pass && (op < 2'd2);
        if (!e_we) e_val = 0;
    endfunction

    task automatic run_req(input logic [1:0] op, input logic [15:0] sel, input logic [1:0] cpl,
                           input logic [1:0] mode, input logic op32, input string tag);
        logic eu, ez, ew;
        logic [31:0] ev, ea;
        int er, waited;
        expect_of(op, sel, cpl, mode, op32, eu, ez, ew, ev, er, ea);
        reads = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_sel = sel; req_cpl = cpl; req_mode = mode; req_op32 = op32;
        @(negedge clk);
        req_valid = 0;
        waited = 0;
        while (!done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check(done === 1'b1, {tag, " R12 done"}, 32'(done), 1);
        check(undef_op === eu, {tag, " R1 undef"}, 32'(undef_op), 32'(eu));
        check(zf === ez, {tag, " zf R5"}, 32'(zf), 32'(ez));
        check(result_we === ew, {tag, " we R12"}, 32'(result_we), 32'(ew));
        if (ew) check(result === ev, {tag, " value R6"}, result, ev);
        check(reads == er, {tag, " reads R4"}, 32'(reads), 32'(er));
        if (er == 2 && reads == 2) begin
            check(rd_addr[0] === ea, {tag, " addr lo R3"}, rd_addr[0], ea);
            check(rd_addr[1] === ea + 4, {tag, " addr hi R3"}, rd_addr[1], ea + 4);
        end
        @(negedge clk);
        check(done === 1'b0, {tag, " R12 pulse"}, 32'(done), 0);
    endtask

    task automatic put(input int slot, input logic [31:0] lo, input logic [31:0] hi);
        mem[slot * 2] = lo;
        mem[slot * 2 + 1] = hi;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1987));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(done === 0 && zf === 0 && result_we === 0 && mem_rd_en === 0,
              "reset R12", {done, zf, result_we, mem_rd_en}, 0);

        put(1, 32'h0000_1234, 32'h0085_F200);   // page-granular writable data, dpl3
        run_req(2'd1, 16'h000B, 2'd3, 2'd1, 1'b1, "glim32 R8");
        check(result === 32'h5123_4FFF, "R8 granular limit", result, 32'h5123_4FFF);
        run_req(2'd1, 16'h000B, 2'd3, 2'd1, 1'b0, "glim16 R9");
        check(result === 32'h0000_4FFF, "R9 short limit", result, 32'h0000_4FFF);
        run_req(2'd3, 16'h000B, 2'd3, 2'd1, 1'b0, "vwr ok R11");

        run_req(2'd0, 16'h000B, 2'd0, 2'd0, 1'b1, "real R1");
        run_req(2'd2, 16'h000B, 2'd0, 2'd2, 1'b1, "v86 R1");
        run_req(2'd0, 16'h0003, 2'd0, 2'd1, 1'b1, "null R2");
        check(zf === 0, "R2 null zf", 32'(zf), 0);
        run_req(2'd1, 16'h0080, 2'd0, 2'd1, 1'b1, "gdt beyond R4");
        run_req(2'd1, 16'h0044, 2'd0, 2'd1, 1'b1, "ldt beyond R4");
        put(64 + 7, 32'h0000_00FF, 32'h0000_E200);
        run_req(2'd1, 16'h003F, 2'd3, 2'd1, 1'b1, "ldt last R3");
        check(zf === 1 && result === 32'h0000_00FF, "R3 ldt slot", result, 32'h0000_00FF);

        put(2, 32'h0000_FFFF, 32'h00CF_9E00);   // conforming readable code, dpl0
        run_req(2'd0, 16'h0013, 2'd3, 2'd1, 1'b1, "conf lar R5");
        check(zf === 1 && result === 32'h00CF_9E00, "R6 mask32", result, 32'h00CF_9E00);
        run_req(2'd0, 16'h0013, 2'd3, 2'd1, 1'b0, "conf lar16 R6");
        check(result === 32'h0000_9E00, "R6 mask16", result, 32'h0000_9E00);
        run_req(2'd2, 16'h0013, 2'd3, 2'd1, 1'b1, "conf verr R10");
        check(zf === 1, "R10 conforming readable", 32'(zf), 1);
        run_req(2'd3, 16'h0013, 2'd0, 2'd1, 1'b1, "code verw R11");
        check(zf === 0, "R11 code rejected", 32'(zf), 0);

        put(3, 32'h0000_FFFF, 32'h0000_B200);   // writable data, dpl1
        run_req(2'd0, 16'h001A, 2'd0, 2'd1, 1'b1, "rpl fail R5");
        check(zf === 0, "R5 rpl above dpl", 32'(zf), 0);
        run_req(2'd0, 16'h0018, 2'd3, 2'd1, 1'b1, "cpl fail R5");

        put(4, 32'h0000_0100, 32'h0000_EC00);   // call gate type 12, dpl3
        run_req(2'd0, 16'h0020, 2'd0, 2'd1, 1'b1, "gate lar R7");
        check(zf === 1, "R7 gate accepted", 32'(zf), 1);
        run_req(2'd1, 16'h0020, 2'd0, 2'd1, 1'b1, "gate lsl R9");
        check(zf === 0, "R9 gate rejected", 32'(zf), 0);
        put(5, 32'h0000_0100, 32'h0000_E700);   // type 7
        run_req(2'd0, 16'h0028, 2'd0, 2'd1, 1'b1, "type7 R7");
        put(6, 32'h0000_0067, 32'h0000_E200);   // LDT descriptor type 2
        run_req(2'd1, 16'h0030, 2'd0, 2'd1, 1'b1, "ldt lsl R9");
        put(7, 32'h0000_FFFF, 32'h0000_F800);   // execute-only code, dpl3
        run_req(2'd2, 16'h0038, 2'd0, 2'd1, 1'b1, "xonly R10");
        check(zf === 0, "R10 execute-only", 32'(zf), 0);
        put(8, 32'h0000_FFFF, 32'h0000_F000);   // read-only data, dpl3
        run_req(2'd3, 16'h0040, 2'd0, 2'd1, 1'b1, "rodata R11");
        check(zf === 0, "R11 read-only", 32'(zf), 0);

        for (int n = 0; n < 300; n++) begin
            logic [15:0] s;
            logic [1:0]  m;
            s = {3'b000, 5'($urandom_range(0, 19)), 5'b00000, 3'($urandom)};
            s = {s[15:8] , 8'h00} >> 5;
            s[2:0] = 3'($urandom);
            m = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd1;
            run_req(2'($urandom), s, 2'($urandom), m, 1'($urandom), "random R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule